// File: doc/BRIEF.md
# Staggered Output Turn-On Sequencer

This block spreads the turn-on of a bank of constant-current LED channels over time so that the supply never sees every channel switch on at the same instant. Channels are arranged as several colour banks (three by default), each holding the same number of index positions (eight by default). Every channel at a given index position shares one delay slot across all banks. Each later index waits one more fixed step, counted in clock ticks from the cycle in which that bank's active-low enable is first seen low.

A stagger-bypass input switches the whole spread off, so that every enabled channel with a data bit of 1 turns on at once. Turn-off has no stagger: raising a bank enable removes that bank's gates at once. A channel whose latched data bit is 0 never turns on. If an enable is raised before its sequence has finished, the sequence is abandoned, and the next enabling edge starts it again from the first index.

Top module: `stagger_seq`

## Requirements
- R1: Channel bit `b*NUM_POS + i` of `data_i` and `gate_o` belongs to bank `b` (enable bit `b` of `bank_en_n_i`) and index `i`, with `i` counted from 0. Index 0 drives its gate in the same cycle in which the bank enable is low, with no added delay.
- R2: With `bypass_i` low, index `i` of a bank whose enable stays low turns on once `i*STEP_TICKS` rising clock edges have sampled that enable low, and not before.
- R3: All banks use the same delay for the same index. Each bank counts only from its own enable, independently of the other banks.
- R4: With `bypass_i` high, every channel of an enabled bank whose data bit is 1 is on with zero added delay.
- R5: Raising a bank enable turns off all gates of that bank at once, without waiting for a clock edge. During and after reset, a bank whose enable is high drives no gate.
- R6: When an enable is sampled high before its sequence completes, the sequence is abandoned. A later enabling edge restarts it from index 0.
- R7: A channel whose data bit is 0 stays off whatever its delay slot, the bypass input or the enable.
- R8: While a bank enable stays low and stagger is active, a lit channel with data 1 stays lit, and no index lights before a lower index whose data bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock; one tick is one period |
| rst_n | input | 1 | Asynchronous active-low reset |
| data_i | input | NUM_BANKS*NUM_POS | Latched channel data, 1 = channel wanted on |
| bank_en_n_i | input | NUM_BANKS | Active-low enable, one bit per bank |
| bypass_i | input | 1 | 1 = no stagger, 0 = stagger by index |
| gate_o | output | NUM_BANKS*NUM_POS | Channel gate drive, 1 = current source on |

## Verification
The hardest situation to reach is an abandoned sequence: the enable has to rise after some indices have lit and others have not, and then fall again, so that the restart can be told apart from a resumed count. The bench drops an enable, holds it for a few ticks that fall part of the way through the index slots, raises it for a single tick and lowers it again. It then checks at every tick that index 0 alone comes back first. Banks are also driven with staggered enable times, so that each counter is checked against its own start and not against a shared one.

// File: rtl/stagger_seq.sv
module stagger_seq #(
  parameter int NUM_BANKS  = 3,
  parameter int NUM_POS    = 8,
  parameter int STEP_TICKS = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_BANKS*NUM_POS-1:0] data_i,
  input  logic [NUM_BANKS-1:0]         bank_en_n_i,
  input  logic                         bypass_i,
  output logic [NUM_BANKS*NUM_POS-1:0] gate_o
);
  localparam int LAST = (NUM_POS - 1) * STEP_TICKS;
  localparam int CW   = $clog2(LAST + 2);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [CW-1:0] ticks;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        ticks <= '0;
      else if (bank_en_n_i[b])
        ticks <= '0;
      else if (ticks != CW'(LAST))
        ticks <= ticks + 1'b1;
    end

    for (genvar i = 0; i < NUM_POS; i++) begin : g_pos
      localparam int SLOT = i * STEP_TICKS;
      wire due = bypass_i || (int'(ticks) >= SLOT);
      assign gate_o[b*NUM_POS+i] = !bank_en_n_i[b] && data_i[b*NUM_POS+i] && due;
    end
  end
endmodule

module stagger_seq_chk #(
  parameter int NUM_BANKS  = 3,
  parameter int NUM_POS    = 8,
  parameter int STEP_TICKS = 3
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic [NUM_BANKS*NUM_POS-1:0] data_i,
  input logic [NUM_BANKS-1:0]         bank_en_n_i,
  input logic                         bypass_i,
  input logic [NUM_BANKS*NUM_POS-1:0] gate_o
);
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_b
    a_r1_idx0_immediate: assert property (@(posedge clk) disable iff (!rst_n)
      (!bank_en_n_i[b] && data_i[b*NUM_POS]) |-> gate_o[b*NUM_POS]);
    for (genvar i = 0; i < NUM_POS; i++) begin : g_i
      localparam int J = b*NUM_POS + i;
      a_r5_off_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        bank_en_n_i[b] |-> !gate_o[J]);
      a_r7_zero_stays_off: assert property (@(posedge clk) disable iff (!rst_n)
        !data_i[J] |-> !gate_o[J]);
      a_r4_bypass_all_on: assert property (@(posedge clk) disable iff (!rst_n)
        (bypass_i && !bank_en_n_i[b] && data_i[J]) |-> gate_o[J]);
      a_r8_stays_lit: assert property (@(posedge clk) disable iff (!rst_n)
        gate_o[J] |=> (bank_en_n_i[b] || !data_i[J] || gate_o[J] || $fell(bypass_i)));
      if (i > 0) begin : g_hi
        a_r2_not_early: assert property (@(posedge clk) disable iff (!rst_n)
          ($fell(bank_en_n_i[b]) && !bypass_i) |-> !gate_o[J]);
        a_r8_in_order: assert property (@(posedge clk) disable iff (!rst_n)
          (gate_o[J] && data_i[J-1] && !bypass_i) |-> gate_o[J-1]);
      end
    end
  end
endmodule

bind stagger_seq stagger_seq_chk #(
  .NUM_BANKS(NUM_BANKS), .NUM_POS(NUM_POS), .STEP_TICKS(STEP_TICKS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .data_i(data_i), .bank_en_n_i(bank_en_n_i),
  .bypass_i(bypass_i), .gate_o(gate_o)
);

// File: tb/stagger_seq_test.sv
module stagger_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 3;
  localparam int NP = 8;
  localparam int ST = 3;
  localparam int W  = NB*NP;

  logic clk = 0;
  logic rst_n = 0;
  logic [W-1:0] data_i = '0;
  logic [NB-1:0] en_n = '1;
  logic bypass_i = 0;
  logic [W-1:0] gate_o;

  int checks = 0;
  int errors = 0;
  int kb [NB];

  always #(CLK_PERIOD/2) clk = ~clk;

  stagger_seq #(.NUM_BANKS(NB), .NUM_POS(NP), .STEP_TICKS(ST)) uut (
    .clk(clk), .rst_n(rst_n), .data_i(data_i), .bank_en_n_i(en_n),
    .bypass_i(bypass_i), .gate_o(gate_o)
  );

  function automatic logic [W-1:0] expect_gates();
    logic [W-1:0] e = '0;
    for (int b = 0; b < NB; b++)
      for (int i = 0; i < NP; i++)
        e[b*NP+i] = !en_n[b] && data_i[b*NP+i] && (bypass_i || kb[b] >= i*ST);
    return e;
  endfunction

  task automatic check(input string tag);
    logic [W-1:0] e = expect_gates();
    checks++;
    if (gate_o !== e) begin
      errors++;
      $display("FAIL %s: gate_o=%h expected=%h", tag, gate_o, e);
    end
  endtask

  task automatic step(input logic [NB-1:0] en, input logic [W-1:0] d,
                      input logic byp, input string tag);
    @(negedge clk);
    for (int b = 0; b < NB; b++) kb[b] = en_n[b] ? 0 : kb[b] + 1;
    en_n = en; data_i = d; bypass_i = byp;
    #2 check(tag);
  endtask

  task automatic hold(input int n, input string tag);
    for (int k = 0; k < n; k++) step(en_n, data_i, bypass_i, tag);
  endtask

  initial begin
    #(CLK_PERIOD*200000);
    errors++; checks++;
    $display("FAIL watchdog: expired, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int b = 0; b < NB; b++) kb[b] = 0;
    #3 check("R5 reset");
    repeat (2) @(negedge clk);
    rst_n = 1;
    step('1, '1, 0, "R5 idle after reset");

    // R1 R2 R3: all banks together, full data
    step('0, '1, 0, "R1 index0 immediate");
    hold(NP*ST + 3, "R2 R3 stagger all banks");
    // R5 turn-off immediate on one bank
    step(3'b010, '1, 0, "R5 bank1 off at once");
    hold(2, "R5 bank1 stays off");
    step('1, '1, 0, "R5 all off");

    // R3: banks started at different times
    step(3'b110, '1, 0, "R3 bank0 first");
    hold(4, "R3 bank0 alone");
    step(3'b100, '1, 0, "R3 bank1 later");
    hold(5, "R3 two banks offset");
    step(3'b000, '1, 0, "R3 bank2 last");
    hold(NP*ST, "R3 three banks offset");
    step('1, '1, 0, "R5 off");

    // R7: sparse data patterns
    for (int p = 0; p < 4; p++) begin
      logic [W-1:0] pat = (p == 0) ? '0 : (p == 1) ? 24'hA5_3C_0F :
                          (p == 2) ? 24'h80_01_7E : 24'h5A_C3_F0;
      step('0, pat, 0, "R7 pattern start");
      hold(NP*ST + 1, "R7 R8 pattern stagger");
      step('1, pat, 0, "R5 R7 pattern off");
    end

    // R4: bypass
    step('0, '1, 1, "R4 bypass all on");
    hold(3, "R4 bypass hold");
    step('1, '1, 1, "R5 bypass off");
    step(3'b011, 24'h3C_FF_81, 1, "R4 bypass bank2 pattern");
    step('1, '1, 0, "R5 off");

    // R6: abort and restart
    for (int a = 1; a < NP*ST; a += 4) begin
      step('0, '1, 0, "R6 start");
      hold(a, "R6 partial");
      step('1, '1, 0, "R6 abort");
      step('0, '1, 0, "R6 restart index0");
      hold(NP*ST + 1, "R6 restarted stagger");
      step('1, '1, 0, "R6 off");
    end

    // R2 with data changing mid-sequence
    step('0, 24'h0F_0F_0F, 0, "R2 partial data");
    hold(6, "R2 partial hold");
    step('0, '1, 0, "R8 data raised mid sequence");
    hold(NP*ST, "R8 finish");
    step('1, '1, 0, "R5 final off");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule